// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block draws a hardware pointer on top of a pixel stream. The display pipeline presents the beam coordinates and the 28-bit colour of the underlying pixel on every clock. The block checks whether the beam lies inside a cursor rectangle, which is always 32 pixels wide. Its height is a programmable line count, and its top-left corner is a programmable origin. Inside that rectangle the block looks up a 2-bit code for the pixel in a small local line store. Depending on the code, it either keeps the underlying colour or replaces it with one of three cursor colours.

Software loads the cursor shape through a line write port, with one 64-bit word per cursor line. It sets the three colours, the origin and the height through a narrow register write port. The result always leaves the block exactly one clock after its inputs, whether or not the cursor covers the pixel. This keeps overlaid pixels and passed-through pixels aligned in the stream.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted and on the first clock after it, `pix_out` is zero. Reset clears all registers to zero, so the cursor height is zero and the cursor is hidden.
- R2: Every output pixel appears on `pix_out` one clock after its inputs. A pixel outside the cursor area comes out equal to its `pix_in`.
- R3: The cursor covers beam columns x with origin_x <= x < origin_x + 32, and no others.
- R4: The cursor covers beam rows y with origin_y <= y < origin_y + height. A height of zero hides the cursor.
- R5: Cursor code 00 is transparent: `pix_out` equals `pix_in` for that pixel.
- R6: Code 01 outputs colour 1, code 10 outputs colour 2, and code 11 outputs colour 3.
- R7: Within a line word, the code of cursor pixel k (k = x - origin_x) sits in bits 2k+1:2k, so pixel 0 is in bits 1:0.
- R8: The cursor line shown is (y - origin_y) mod 64. Heights above 64 repeat the stored lines.
- R9: The register write port has these addresses: 0 is colour 1, 1 is colour 2, 2 is colour 3, 3 is origin x, 4 is origin y, and 5 is height. Origin x, origin y and height take bits 11:0 of the data. Writes to addresses 6 and 7 have no effect.
- R10: A line write with `line_we` high stores `line_wdata` at line `line_addr`. The new shape is used from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beam_x | input | 12 | Current beam column |
| beam_y | input | 12 | Current beam row |
| pix_in | input | 28 | Underlying pixel colour |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 28 | Register write data |
| line_we | input | 1 | Cursor line write strobe |
| line_addr | input | 6 | Cursor line index |
| line_wdata | input | 64 | Cursor line data, 32 codes of 2 bits |
| pix_out | output | 28 | Resulting colour, one clock later |

## Verification
The hardest cases to reach are those that depend on row wrap and on the exact last column and last row of the rectangle. The row wrap only appears when the programmed height exceeds the 64 stored lines. The bench therefore sets a height of 70 and fills each line with a pattern computed from its index and pixel position. It then visits rows 64 and 69 past the origin, which must show lines 0 and 5. It also visits columns and rows one step on either side of each edge. Transparency is checked on pixels whose code is 00 inside the rectangle, not only on pixels outside it.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    localparam int CUR_WIDTH = 32;
    localparam int CODE_W    = 2;

    typedef enum logic [1:0] {
        CODE_CLEAR = 2'b00,
        CODE_COL1  = 2'b01,
        CODE_COL2  = 2'b10,
        CODE_COL3  = 2'b11
    } cur_code_e;

    localparam logic [2:0] RA_COL1  = 3'd0;
    localparam logic [2:0] RA_COL2  = 3'd1;
    localparam logic [2:0] RA_COL3  = 3'd2;
    localparam logic [2:0] RA_ORGX  = 3'd3;
    localparam logic [2:0] RA_ORGY  = 3'd4;
    localparam logic [2:0] RA_HGT   = 3'd5;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int COLOR_W = 28,
    parameter int COORD_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [2:0]                 reg_addr,
    input  logic [COLOR_W-1:0]         reg_wdata,
    output logic [2:0][COLOR_W-1:0]    colours,
    output logic [COORD_W-1:0]         org_x,
    output logic [COORD_W-1:0]         org_y,
    output logic [COORD_W-1:0]         height
);
    logic unused_hi;
    assign unused_hi = ^reg_wdata[COLOR_W-1:COORD_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            colours <= '0;
            org_x   <= '0;
            org_y   <= '0;
            height  <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                RA_COL1: colours[0] <= reg_wdata;
                RA_COL2: colours[1] <= reg_wdata;
                RA_COL3: colours[2] <= reg_wdata;
                RA_ORGX: org_x      <= reg_wdata[COORD_W-1:0];
                RA_ORGY: org_y      <= reg_wdata[COORD_W-1:0];
                RA_HGT:  height     <= reg_wdata[COORD_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cursor_linebuf.sv
module cursor_linebuf #(
    parameter int LINES  = 64,
    parameter int WORD_W = 64,
    localparam int AW    = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] store [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit #(
    parameter int COORD_W = 12,
    parameter int CUR_W   = 32,
    parameter int LINES   = 64,
    localparam int CW     = $clog2(CUR_W),
    localparam int AW     = $clog2(LINES)
) (
    input  logic [COORD_W-1:0] beam_x,
    input  logic [COORD_W-1:0] beam_y,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [COORD_W-1:0] height,
    output logic               hit,
    output logic [CW-1:0]      col_idx,
    output logic [AW-1:0]      row_idx
);
    logic [COORD_W:0] dx, dy;

    always_comb begin
        dx      = {1'b0, beam_x} - {1'b0, org_x};
        dy      = {1'b0, beam_y} - {1'b0, org_y};
        hit     = !dx[COORD_W] && (dx < (COORD_W+1)'(CUR_W))
               && !dy[COORD_W] && (dy < {1'b0, height});
        col_idx = dx[CW-1:0];
        row_idx = dy[AW-1:0];
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int COLOR_W = 28,
    parameter int COORD_W = 12,
    parameter int LINES   = 64,
    localparam int WORD_W = CUR_WIDTH * CODE_W,
    localparam int AW     = $clog2(LINES),
    localparam int CW     = $clog2(CUR_WIDTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] beam_x,
    input  logic [COORD_W-1:0] beam_y,
    input  logic [COLOR_W-1:0] pix_in,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [COLOR_W-1:0] reg_wdata,
    input  logic               line_we,
    input  logic [AW-1:0]      line_addr,
    input  logic [WORD_W-1:0]  line_wdata,
    output logic [COLOR_W-1:0] pix_out
);
    logic [2:0][COLOR_W-1:0] colours;
    logic [COORD_W-1:0]      org_x, org_y, height;
    logic                    hit;
    logic [CW-1:0]           col_idx;
    logic [AW-1:0]           row_idx;
    logic [WORD_W-1:0]       line_word;
    cur_code_e               code;
    logic [COLOR_W-1:0]      next_pix;

    cursor_regs #(.COLOR_W(COLOR_W), .COORD_W(COORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .colours(colours), .org_x(org_x),
        .org_y(org_y), .height(height)
    );

    cursor_linebuf #(.LINES(LINES), .WORD_W(WORD_W)) u_lines (
        .clk(clk), .wr_en(line_we), .wr_addr(line_addr), .wr_data(line_wdata),
        .rd_addr(row_idx), .rd_data(line_word)
    );

    cursor_hit #(.COORD_W(COORD_W), .CUR_W(CUR_WIDTH), .LINES(LINES)) u_hit (
        .beam_x(beam_x), .beam_y(beam_y), .org_x(org_x), .org_y(org_y),
        .height(height), .hit(hit), .col_idx(col_idx), .row_idx(row_idx)
    );

    assign code = cur_code_e'(line_word[{col_idx, 1'b0} +: CODE_W]);

    always_comb begin
        next_pix = pix_in;
        if (hit) begin
            unique case (code)
                CODE_CLEAR: next_pix = pix_in;
                CODE_COL1:  next_pix = colours[0];
                CODE_COL2:  next_pix = colours[1];
                CODE_COL3:  next_pix = colours[2];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pix_out <= '0;
        else        pix_out <= next_pix;
    end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int COLOR_W = 28,
    parameter int COORD_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [COORD_W-1:0]      beam_x,
    input logic [COORD_W-1:0]      beam_y,
    input logic [COORD_W-1:0]      org_x,
    input logic [COORD_W-1:0]      org_y,
    input logic [COORD_W-1:0]      height,
    input logic                    hit,
    input logic [1:0]              code,
    input logic [2:0][COLOR_W-1:0] colours,
    input logic [COLOR_W-1:0]      pix_in,
    input logic [COLOR_W-1:0]      pix_out
);
    p_pass_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> pix_out == $past(pix_in));
    p_left_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> beam_x >= org_x);
    p_top_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> beam_y >= org_y);
    p_zero_height_r4: assert property (@(posedge clk) disable iff (!rst_n)
        height == '0 |-> !hit);
    p_transparent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && code == 2'b00) |=> pix_out == $past(pix_in));
    p_colour1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && code == 2'b01) |=> pix_out == $past(colours[0]));
    p_colour2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && code == 2'b10) |=> pix_out == $past(colours[1]));
    p_colour3_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && code == 2'b11) |=> pix_out == $past(colours[2]));
    p_reset_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> pix_out == '0);
endmodule

bind cursor_overlay cursor_overlay_chk #(.COLOR_W(COLOR_W), .COORD_W(COORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .beam_x(beam_x), .beam_y(beam_y),
    .org_x(org_x), .org_y(org_y), .height(height), .hit(hit),
    .code(code), .colours(colours), .pix_in(pix_in), .pix_out(pix_out)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [11:0] beam_x = 0, beam_y = 0;
    logic [27:0] pix_in = 0;
    logic        reg_we = 0;
    logic [2:0]  reg_addr = 0;
    logic [27:0] reg_wdata = 0;
    logic        line_we = 0;
    logic [5:0]  line_addr = 0;
    logic [63:0] line_wdata = 0;
    logic [27:0] pix_out;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    localparam logic [27:0] C1 = 28'h1111111, C2 = 28'h2222222, C3 = 28'h3333333;
    localparam int N = 13;
    // x, y, expected selection (0 = underlying pixel, 1..3 = colour)
    localparam int VX  [N] = '{ 99, 100, 101, 102, 103, 131, 132, 100, 100, 100, 100, 102,  0};
    localparam int VY  [N] = '{ 50,  50,  50,  50,  50,  50,  50,  49,  51, 119, 120, 114,  0};
    localparam int VS  [N] = '{  0,   0,   1,   2,   3,   3,   0,   0,   1,   1,   0,   2,  0};
    localparam string VR [N] = '{"R3","R5","R6","R6","R6","R3","R3","R4","R7","R8","R4","R8","R2"};

    cursor_overlay i_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .beam_x(beam_x), .beam_y(beam_y),
        .pix_in(pix_in), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .line_we(line_we), .line_addr(line_addr),
        .line_wdata(line_wdata), .pix_out(pix_out)
    );

    always #2 clk = ~clk;

    function automatic logic [27:0] under(input int x, input int y);
        return {4'hA, 12'(y), 12'(x)};
    endfunction

    function automatic logic [27:0] pick(input int s, input int x, input int y);
        case (s)
            1: return C1;
            2: return C2;
            3: return C3;
            default: return under(x, y);
        endcase
    endfunction

    task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pix_out=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [27:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic wr_line(input int a, input logic [63:0] d);
        @(negedge clk);
        line_we = 1; line_addr = 6'(a); line_wdata = d;
        @(negedge clk);
        line_we = 0;
    endtask

    // present a pixel, check its result one clock later
    task automatic probe(input string req, input int x, input int y, input logic [27:0] exp);
        @(negedge clk);
        beam_x = 12'(x); beam_y = 12'(y); pix_in = under(x, y);
        @(negedge clk);
        check(req, pix_out, exp);
    endtask

    function automatic logic [63:0] pattern(input int line);
        logic [63:0] w = '0;
        for (int k = 0; k < 32; k++) w[2*k +: 2] = 2'((k + line) % 4);
        return w;
    endfunction

    initial begin
        repeat (2) @(negedge clk);
        // R1: output cleared during reset
        check("R1", pix_out, 28'h0);
        @(negedge clk);
        rst_n = 1;
        // R1: after reset the height is zero, so the cursor stays hidden
        probe("R1", 0, 0, under(0, 0));

        for (int i = 0; i < 64; i++) wr_line(i, pattern(i));
        wr_reg(3'd0, C1);
        wr_reg(3'd1, C2);
        wr_reg(3'd2, C3);
        wr_reg(3'd3, 28'd100);
        wr_reg(3'd4, 28'd50);
        // R4: height still zero, cursor hidden even at a covered position
        probe("R4", 101, 50, under(101, 50));
        wr_reg(3'd5, 28'd70);

        for (int i = 0; i < N; i++)
            probe(VR[i], VX[i], VY[i], pick(VS[i], VX[i], VY[i]));

        // R9: writes to unused addresses leave colours and geometry alone
        wr_reg(3'd6, 28'h0FFFFFF);
        wr_reg(3'd7, 28'h0000000);
        probe("R9", 101, 50, C1);
        probe("R9", 103, 50, C3);

        // R10 / R7: rewrite line 1 with a single code 10 at pixel 17
        wr_line(1, 64'h1 << 35);
        probe("R10", 117, 51, C2);
        probe("R7", 116, 51, under(116, 51));
        probe("R7", 118, 51, under(118, 51));

        // R3: cursor at origin zero reaches column 31 only
        wr_reg(3'd3, 28'd0);
        probe("R3", 31, 50, C3);
        probe("R3", 32, 50, under(32, 50));

        // R2: back-to-back pixels outside the area
        probe("R2", 500, 400, under(500, 400));
        probe("R2", 501, 401, under(501, 401));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule